// File: doc/BRIEF.md
# Stack Bytecode Folding Unit

This unit sits between a bytecode fetch stage and a register-style execution stage. It takes a stream of stack-machine bytecodes, each with an operand index. It sorts every bytecode by the way it changes the operand stack. It then rewrites short runs of loads, an arithmetic operation and a store as one three-address operation. That operation names its source and destination locals directly, so the operand stack is never read or written for the run. A folded load-load-add-store therefore needs no stack reads and no stack writes, where the unfolded run needs three of each. The two local reads and the one local write remain.

Bytecodes enter a four-entry lookahead queue through a valid/ready handshake. Each cycle, a matcher looks at the head of the queue and picks the longest pattern that is complete. When the queue holds the beginning of a longer pattern and another bytecode is being offered, the matcher waits for it. When nothing more is offered, the matcher emits what it has at once, so the stream always makes progress. Results leave through a second valid/ready handshake. Each result carries an opcode, two source fields, a destination field, a stack/local flag for each of the three, and the number of bytecodes it replaces.

Top module: `fold_unit`

## Requirements
- R1: The two top bits of `in_opcode` give the class: 00 producer (push from local `in_index`), 01 consumer (pop into local `in_index`), 10 operation, 11 special. An operation is foldable only when its low three bits are 0 to 4 (add, sub, and, or, xor); the values 5 to 7 are not foldable.
- R2: Producer, producer, foldable operation, consumer at the queue head gives one result. Its opcode is the operation's opcode, source A is the first index, source B is the second index and the destination is the consumer's index. All three stack flags are 0 and the length is 4.
- R3: Producer, producer, foldable operation (with no consumer after it) gives the operation's opcode, sources A and B from the two producers, destination 0 with the destination stack flag 1, source flags 0, and length 3.
- R4: Producer, foldable operation, consumer gives the operation's opcode with source A from the stack (index 0, flag 1), source B from the producer's local (flag 0), destination the consumer's local (flag 0), and length 3.
- R5: The patterns are tried longest first, in the order of R2, then R3, then R4, then a single bytecode. On a continuous input the results equal a greedy scan of the stream with that priority.
- R6: A special bytecode or a non-foldable operation is never part of a folded result; it always leaves as a single result of length 1.
- R7: A single result has the bytecode's own opcode. Source A is its index, with flag 1 unless it is a producer. Source B is 0 with flag 1. The destination is its index with flag 0 for a consumer, and otherwise 0 with flag 1. The length is 1.
- R8: While the queue holds the start of a longer pattern and `in_valid` is high, no result is offered. When `in_valid` is low, the best available result is offered in the same cycle.
- R9: While `out_valid` is high and `out_ready` low, `out_valid` stays high and all output fields stay unchanged on the next cycle.
- R10: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` is 0 exactly while four bytecodes are buffered.
- R11: Results leave in stream order. Every bytecode accepted is covered by exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bytecode offered |
| in_ready | output | 1 | Queue has room |
| in_opcode | input | 8 | Bytecode, class in bits 7:6 |
| in_index | input | IDX_W | Local index operand |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken |
| out_opcode | output | 8 | Result opcode |
| out_src_a | output | IDX_W | First source local |
| out_src_a_stk | output | 1 | First source is the stack |
| out_src_b | output | IDX_W | Second source local |
| out_src_b_stk | output | 1 | Second source is the stack |
| out_dst | output | IDX_W | Destination local |
| out_dst_stk | output | 1 | Destination is the stack |
| out_len | output | 3 | Bytecodes replaced (1, 3 or 4) |

## Verification
A wrong queue count or a wrong shift shows up in the next result as a length that is too long for the bytecodes accepted, an index taken from the wrong entry, or a bytecode missing from or repeated in the output order. Each of these is visible in the first result after the fault. A wrong wait decision shows as a fold that is missed or a result that appears too early, and shows within the burst where it happens. A lost hold decision under backpressure changes the offered fields while `out_ready` is low, and this is visible one cycle later.

// File: rtl/fold_pkg.sv
package fold_pkg;
    localparam int OPC_W = 8;
    localparam int LEN_W = 3;
    localparam logic [2:0] FOLD_MAX_SUB = 3'd4;

    typedef enum logic [1:0] {
        CLS_PROD = 2'b00,
        CLS_CONS = 2'b01,
        CLS_OPER = 2'b10,
        CLS_SPEC = 2'b11
    } cls_e;

    function automatic cls_e class_of(input logic [OPC_W-1:0] opc);
        return cls_e'(opc[7:6]);
    endfunction
endpackage

// File: rtl/fold_classify.sv
module fold_classify
    import fold_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output cls_e             cls,
    output logic             foldable
);
    always_comb begin
        cls      = class_of(opc);
        foldable = (cls == CLS_OPER) && (opc[2:0] <= FOLD_MAX_SUB);
    end
endmodule

// File: rtl/fold_queue.sv
module fold_queue
    import fold_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [OPC_W-1:0]                  in_opcode,
    input  logic [IDX_W-1:0]                  in_index,
    input  logic [LEN_W-1:0]                  deq_len,
    output logic [DEPTH-1:0][OPC_W-1:0]       q_opc,
    output logic [DEPTH-1:0][IDX_W-1:0]       q_idx,
    output logic [CNT_W-1:0]                  q_cnt
);
    typedef struct packed {
        logic [DEPTH-1:0][OPC_W-1:0] opc;
        logic [DEPTH-1:0][IDX_W-1:0] idx;
        logic [CNT_W-1:0]            cnt;
    } qst_t;

    qst_t st_d, st_q;
    logic in_fire;
    int   rem;

    assign in_ready = (int'(st_q.cnt) < DEPTH);
    assign in_fire  = in_valid && in_ready;
    assign q_opc    = st_q.opc;
    assign q_idx    = st_q.idx;
    assign q_cnt    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        rem  = int'(st_q.cnt) - int'(deq_len);
        for (int i = 0; i < DEPTH; i++) begin
            if (i + int'(deq_len) < DEPTH) begin
                st_d.opc[i] = st_q.opc[i + int'(deq_len)];
                st_d.idx[i] = st_q.idx[i + int'(deq_len)];
            end else begin
                st_d.opc[i] = '0;
                st_d.idx[i] = '0;
            end
        end
        if (in_fire && rem >= 0 && rem < DEPTH) begin
            st_d.opc[rem] = in_opcode;
            st_d.idx[rem] = in_index;
        end
        st_d.cnt = CNT_W'(rem + (in_fire ? 1 : 0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH);

    p_deq_fits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(deq_len) <= int'(st_q.cnt));
endmodule

// File: rtl/fold_matcher.sv
module fold_matcher
    import fold_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0][OPC_W-1:0]  q_opc,
    input  logic [DEPTH-1:0][IDX_W-1:0]  q_idx,
    input  logic [CNT_W-1:0]             q_cnt,
    input  cls_e [DEPTH-1:0]             q_cls,
    input  logic [DEPTH-1:0]             q_fold,
    input  logic                         in_valid,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [OPC_W-1:0]             out_opcode,
    output logic [IDX_W-1:0]             out_src_a,
    output logic                         out_src_a_stk,
    output logic [IDX_W-1:0]             out_src_b,
    output logic                         out_src_b_stk,
    output logic [IDX_W-1:0]             out_dst,
    output logic                         out_dst_stk,
    output logic [LEN_W-1:0]             out_len,
    output logic [LEN_W-1:0]             deq_len
);
    typedef struct packed {
        logic             hold;
        logic [LEN_W-1:0] len;
    } mst_t;

    mst_t st_d, st_q;
    int   n;
    logic m4, m3a, m3b, ext, wait_more;
    logic [LEN_W-1:0] auto_len, sel_len;

    logic fold_unused;
    assign fold_unused = ^{q_fold[0], q_fold[DEPTH-1:3], q_opc[DEPTH-1:3]};

    always_comb begin
        n   = int'(q_cnt);
        m4  = (n >= 4) && q_cls[0] == CLS_PROD && q_cls[1] == CLS_PROD
              && q_fold[2] && q_cls[3] == CLS_CONS;
        m3a = (n >= 3) && q_cls[0] == CLS_PROD && q_cls[1] == CLS_PROD && q_fold[2];
        m3b = (n >= 3) && q_cls[0] == CLS_PROD && q_fold[1] && q_cls[2] == CLS_CONS;
        ext = (n == 1 && q_cls[0] == CLS_PROD)
           || (n == 2 && q_cls[0] == CLS_PROD && (q_cls[1] == CLS_PROD || q_fold[1]))
           || (n == 3 && m3a && n < DEPTH);
        wait_more = in_valid && ext;

        if (m4)              auto_len = 3'd4;
        else if (m3a || m3b) auto_len = 3'd3;
        else                 auto_len = 3'd1;
        sel_len = st_q.hold ? st_q.len : auto_len;

        out_valid     = (n != 0) && (st_q.hold || !wait_more);
        out_len       = sel_len;
        out_opcode    = q_opc[0];
        out_src_a     = q_idx[0];
        out_src_a_stk = (q_cls[0] != CLS_PROD);
        out_src_b     = '0;
        out_src_b_stk = 1'b1;
        out_dst       = (q_cls[0] == CLS_CONS) ? q_idx[0] : '0;
        out_dst_stk   = (q_cls[0] != CLS_CONS);

        if (sel_len == 3'd4) begin
            out_opcode    = q_opc[2];
            out_src_a     = q_idx[0];
            out_src_a_stk = 1'b0;
            out_src_b     = q_idx[1];
            out_src_b_stk = 1'b0;
            out_dst       = q_idx[3];
            out_dst_stk   = 1'b0;
        end else if (sel_len == 3'd3 && m3a) begin
            out_opcode    = q_opc[2];
            out_src_a     = q_idx[0];
            out_src_a_stk = 1'b0;
            out_src_b     = q_idx[1];
            out_src_b_stk = 1'b0;
            out_dst       = '0;
            out_dst_stk   = 1'b1;
        end else if (sel_len == 3'd3) begin
            out_opcode    = q_opc[1];
            out_src_a     = '0;
            out_src_a_stk = 1'b1;
            out_src_b     = q_idx[0];
            out_src_b_stk = 1'b0;
            out_dst       = q_idx[2];
            out_dst_stk   = 1'b0;
        end

        st_d.hold = out_valid && !out_ready;
        st_d.len  = sel_len;
        deq_len   = (out_valid && out_ready) ? sel_len : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_opcode)
            && $stable(out_src_a) && $stable(out_src_a_stk)
            && $stable(out_src_b) && $stable(out_src_b_stk)
            && $stable(out_dst) && $stable(out_dst_stk) && $stable(out_len));

    p_special_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && q_cls[0] == CLS_SPEC |-> out_len == 3'd1);

    p_fold4_locals_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len == 3'd4 |-> !out_src_a_stk && !out_src_b_stk && !out_dst_stk);

    p_len_le_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(out_len) <= int'(q_cnt));
endmodule

// File: rtl/fold_unit.sv
module fold_unit
    import fold_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_opcode,
    input  logic [IDX_W-1:0] in_index,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_opcode,
    output logic [IDX_W-1:0] out_src_a,
    output logic             out_src_a_stk,
    output logic [IDX_W-1:0] out_src_b,
    output logic             out_src_b_stk,
    output logic [IDX_W-1:0] out_dst,
    output logic             out_dst_stk,
    output logic [2:0]       out_len
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][OPC_W-1:0] q_opc;
    logic [DEPTH-1:0][IDX_W-1:0] q_idx;
    logic [CNT_W-1:0]            q_cnt;
    cls_e [DEPTH-1:0]            q_cls;
    logic [DEPTH-1:0]            q_fold;
    logic [LEN_W-1:0]            deq_len;

    fold_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_opcode (in_opcode),
        .in_index  (in_index),
        .deq_len   (deq_len),
        .q_opc     (q_opc),
        .q_idx     (q_idx),
        .q_cnt     (q_cnt)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cls
        fold_classify u_cls (
            .opc      (q_opc[g]),
            .cls      (q_cls[g]),
            .foldable (q_fold[g])
        );
    end

    fold_matcher #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_opc         (q_opc),
        .q_idx         (q_idx),
        .q_cnt         (q_cnt),
        .q_cls         (q_cls),
        .q_fold        (q_fold),
        .in_valid      (in_valid),
        .out_ready     (out_ready),
        .out_valid     (out_valid),
        .out_opcode    (out_opcode),
        .out_src_a     (out_src_a),
        .out_src_a_stk (out_src_a_stk),
        .out_src_b     (out_src_b),
        .out_src_b_stk (out_src_b_stk),
        .out_dst       (out_dst),
        .out_dst_stk   (out_dst_stk),
        .out_len       (out_len),
        .deq_len       (deq_len)
    );
endmodule

// File: tb/fold_unit_test.sv
`timescale 1ns/1ps
module fold_unit_test;
    localparam int IDX_W = 4;
    localparam int VW = 8 + 3 * IDX_W + 3 + 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, in_valid, in_ready, out_valid, out_ready;
    logic [7:0] in_opcode, out_opcode;
    logic [IDX_W-1:0] in_index, out_src_a, out_src_b, out_dst;
    logic out_src_a_stk, out_src_b_stk, out_dst_stk;
    logic [2:0] out_len;

    fold_unit #(.IDX_W(IDX_W), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_index(in_index), .out_valid(out_valid),
        .out_ready(out_ready), .out_opcode(out_opcode), .out_src_a(out_src_a),
        .out_src_a_stk(out_src_a_stk), .out_src_b(out_src_b),
        .out_src_b_stk(out_src_b_stk), .out_dst(out_dst),
        .out_dst_stk(out_dst_stk), .out_len(out_len)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]       s_opc [64];
    logic [IDX_W-1:0] s_idx [64];
    logic [VW-1:0]    e_vec [64];
    int               e_cnt;

    function automatic logic [VW-1:0] pk(input logic [7:0] op, input logic [IDX_W-1:0] a,
        input logic as, input logic [IDX_W-1:0] b, input logic bs,
        input logic [IDX_W-1:0] d, input logic ds, input logic [2:0] len);
        return {op, a, as, b, bs, d, ds, len};
    endfunction

    function automatic logic [VW-1:0] act_vec();
        return {out_opcode, out_src_a, out_src_a_stk, out_src_b, out_src_b_stk,
                out_dst, out_dst_stk, out_len};
    endfunction

    function automatic int cls(input logic [7:0] op);
        return int'(op[7:6]);
    endfunction

    function automatic bit fld(input logic [7:0] op);
        return op[7:6] == 2'b10 && op[2:0] <= 3'd4;
    endfunction

    // Greedy reference scan, R5 priority order
    task automatic model(input int n);
        int i = 0;
        e_cnt = 0;
        while (i < n) begin
            if (i + 3 < n && cls(s_opc[i]) == 0 && cls(s_opc[i+1]) == 0
                && fld(s_opc[i+2]) && cls(s_opc[i+3]) == 1) begin
                e_vec[e_cnt] = pk(s_opc[i+2], s_idx[i], 0, s_idx[i+1], 0, s_idx[i+3], 0, 3'd4);
                i += 4;
            end else if (i + 2 < n && cls(s_opc[i]) == 0 && cls(s_opc[i+1]) == 0
                && fld(s_opc[i+2])) begin
                e_vec[e_cnt] = pk(s_opc[i+2], s_idx[i], 0, s_idx[i+1], 0, '0, 1, 3'd3);
                i += 3;
            end else if (i + 2 < n && cls(s_opc[i]) == 0 && fld(s_opc[i+1])
                && cls(s_opc[i+2]) == 1) begin
                e_vec[e_cnt] = pk(s_opc[i+1], '0, 1, s_idx[i], 0, s_idx[i+2], 0, 3'd3);
                i += 3;
            end else begin
                e_vec[e_cnt] = pk(s_opc[i], s_idx[i], cls(s_opc[i]) != 0, '0, 1,
                    (cls(s_opc[i]) == 1) ? s_idx[i] : '0, cls(s_opc[i]) != 1, 3'd1);
                i += 1;
            end
            e_cnt++;
        end
    endtask

    function automatic string req_of(input logic [VW-1:0] v);
        if (v[2:0] == 3'd4) return "R2";
        if (v[2:0] == 3'd3 && v[3]) return "R3";
        if (v[2:0] == 3'd3) return "R4";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input logic [VW-1:0] got,
                         input logic [VW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic run_burst(input int n, input bit bp, input int stall, input string tag);
        int ptr = 0;
        int got = 0;
        int cyc = 0;
        bit prev_stall = 0;
        logic [VW-1:0] prev_vec = '0;
        model(n);
        while ((ptr < n || got < e_cnt) && cyc < 300) begin
            @(negedge clk);
            in_valid  = (ptr < n);
            in_opcode = (ptr < n) ? s_opc[ptr] : 8'h00;
            in_index  = (ptr < n) ? s_idx[ptr] : '0;
            if (cyc < stall) out_ready = 1'b0;
            else if (bp)     out_ready = lfsr[0];
            else             out_ready = 1'b1;
            step_lfsr();
            #1;
            if (prev_stall)
                check(out_valid && act_vec() == prev_vec, "R9 hold", act_vec(), prev_vec);
            if (stall > 0 && cyc == stall - 1)
                check(!in_ready && ptr == 4, "R10 full", VW'(ptr), VW'(4));
            if (out_valid && out_ready) begin
                if (got < e_cnt)
                    check(act_vec() == e_vec[got],
                          {req_of(e_vec[got]), " ", tag}, act_vec(), e_vec[got]);
                else
                    check(1'b0, {"R11 extra ", tag}, act_vec(), '0);
                got++;
            end
            prev_stall = out_valid && !out_ready;
            prev_vec   = act_vec();
            if (in_valid && in_ready) ptr++;
            cyc++;
        end
        if (cyc >= 300) check(1'b0, {"R8 stuck ", tag}, VW'(got), VW'(e_cnt));
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        #1;
        check(!out_valid && in_ready, {"R11 drained ", tag}, VW'(out_valid), '0);
    endtask

    function automatic logic [7:0] sym_opc(input int s, input int b);
        case (s)
            0:       return 8'h00 + 8'(b % 8);
            1:       return 8'h40 + 8'(b % 8);
            2:       return 8'h80 + 8'(b % 5);
            3:       return 8'h85 + 8'(b % 3);
            default: return 8'hC0 + 8'(b % 64);
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_opcode = '0; in_index = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready, "R10 reset", VW'({out_valid, in_ready}), VW'(1));

        // Exhaustive four-bytecode sweep: R1 classes, R5 order, R6 barriers, R8 flush, R11 order
        for (int b = 0; b < 625; b++) begin
            int v = b;
            for (int j = 0; j < 4; j++) begin
                s_opc[j] = sym_opc(v % 5, b + j);
                s_idx[j] = IDX_W'((b * 5 + j * 3) % 16);
                v = v / 5;
            end
            run_burst(4, b[0], 0, "R1/R5/R6/R8/R11 sweep");
        end

        // Full-queue backpressure: R10
        for (int j = 0; j < 5; j++) begin
            s_opc[j] = 8'h00;
            s_idx[j] = IDX_W'(j + 1);
        end
        run_burst(5, 1'b0, 8, "R10 stall");

        // Long pseudo-random streams under backpressure: R5, R9, R11
        for (int r = 0; r < 4; r++) begin
            for (int j = 0; j < 64; j++) begin
                step_lfsr();
                s_opc[j] = sym_opc(int'(lfsr[7:0]) % 5, j + r);
                s_idx[j] = lfsr[11:8];
            end
            run_burst(64, r[0], 0, "R5/R9/R11 stream");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule